// File: doc/BRIEF.md
# Memory-Mapped Serial Port Registers

This block is a small asynchronous serial port that hangs off a processor's word-wide memory bus. It decodes two word addresses. One holds a divider that sets the serial bit length in system clocks. The other is a combined data port: a store to it sends a byte on the transmit line, and a load from it returns the last byte that arrived on the receive line. Framing is fixed at one start bit, eight data bits sent least significant first, no parity and one stop bit.

The receiver holds exactly one byte. When nothing is waiting, a load of the data port returns a word of all ones, so software can poll the one address with no separate status word. A store to the data port while a frame is still going out is stalled: the block keeps the bus ready signal low until the transmitter is free. Register accesses that are not stalled complete in the cycle they are presented, because ready is combinational.

Top module: `uart_regif`

## Requirements
- R1: The divider register is at address 0x02000004. It reads back as a full 32-bit word and resets to 1. Its value is the number of system clocks per serial bit, and a value of 0 acts as 1.
- R2: A store to the divider updates byte lane i (bits 8i+7:8i) only when bus_wstrb[i] is 1. The other lanes keep their old value.
- R3: A store to the data port at 0x02000008 with any bus_wstrb bit set sends bus_wdata[7:0] on uart_tx. The frame is a low start bit, then eight data bits least significant first, then a high stop bit. Each bit lasts one divider period, and the start bit begins on the clock edge that accepts the store. uart_tx is high whenever nothing is being sent.
- R4: A store to the data port made while a frame is being sent gets bus_ready low until the transmitter is idle. A store presented right after an accepted one is accepted 10*divider+1 cycles after the first.
- R5: A load of the data port (bus_wstrb all zero) with a byte waiting returns that byte in bits 7:0 and zero in bits 31:8.
- R6: A load of the data port with no byte waiting returns 0xFFFFFFFF.
- R7: A load of the data port removes the waiting byte, so the next load returns 0xFFFFFFFF unless a new byte has arrived.
- R8: The receiver starts a frame on a falling edge of uart_rx and samples each bit near its middle. A frame whose stop bit is low is dropped and leaves the buffer unchanged.
- R9: A byte that arrives while an older one is still unread replaces it.
- R10: An access to any other address never gets bus_ready and changes no register. Accesses to the two registers that are not stalled get bus_ready in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Bus access request |
| bus_addr | input | 32 | Byte address of the access |
| bus_wstrb | input | 4 | Byte-lane write enables; all zero means a load |
| bus_wdata | input | 32 | Store data |
| bus_rdata | output | 32 | Load data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes on this clock edge |
| uart_tx | output | 1 | Serial transmit line, idles high |
| uart_rx | input | 1 | Serial receive line, idles high |

## Verification
The assertions assume that a bus master holds bus_valid, bus_addr and bus_wstrb steady until bus_ready is seen, and that a load is marked by an all-zero bus_wstrb. The bench drives every access from one task that keeps the request fixed until the handshake and then drops bus_valid. Receive frames are sent at the programmed divider with divider values of at least 4, so the mid-bit sampling has margin over the input synchronizer delay. Random divider, transmit and receive values come from a fixed-seed generator and are mixed with directed cases for lane masks, stalls, dropped frames and overwrites.

// File: rtl/uart_regif_pkg.sv
// Shared constants and types for the serial port register block.
// Assumes fixed 8N1 framing; only the bit length is programmable.
package uart_regif_pkg;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = DATA_BITS + 2;
    localparam int BUS_W      = 32;
    localparam int LANES      = BUS_W / 8;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;
endpackage

// File: rtl/uart_tx_engine.sv
// Serializer: sends one 8N1 frame per start pulse.
// Assumes start is only raised while busy is low. The first bit is driven
// from the edge that sees start. busy stays high for FRAME_BITS*div cycles.
module uart_tx_engine
    import uart_regif_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] data,
    output logic                 tx,
    output logic                 busy
);
    localparam int CNT_BITS_W = $clog2(FRAME_BITS);

    logic [FRAME_BITS-1:0] shreg;
    logic [DIV_W-1:0]      cnt;
    logic [CNT_BITS_W-1:0] left;
    logic [DIV_W-1:0]      eff_div;

    // Purpose: a divider of zero acts as one clock per bit.
    always_comb eff_div = (div == '0) ? DIV_W'(1) : div;

    // Purpose: load, time and shift the frame one bit per divider period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '1;
            cnt   <= '0;
            left  <= '0;
            busy  <= 1'b0;
        end else if (start && !busy) begin
            shreg <= {1'b1, data, 1'b0};
            cnt   <= eff_div - 1'b1;
            left  <= CNT_BITS_W'(FRAME_BITS - 1);
            busy  <= 1'b1;
        end else if (busy) begin
            if (cnt == '0) begin
                if (left == '0) begin
                    busy <= 1'b0;
                end else begin
                    shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                    left  <= left - 1'b1;
                    cnt   <= eff_div - 1'b1;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    assign tx = shreg[0];
endmodule

// File: rtl/uart_rx_engine.sv
// Deserializer: finds a start bit on a falling line edge, samples each bit
// near its middle, and gives a one-cycle valid pulse for a frame whose stop
// bit is high. Assumes the line idles high; a two-flop synchronizer is used.
module uart_rx_engine
    import uart_regif_pkg::*;
#(
    parameter int DIV_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_W-1:0]     div,
    input  logic                 rx,
    output logic                 valid,
    output logic [DATA_BITS-1:0] data
);
    localparam int IDX_W = $clog2(DATA_BITS);

    rx_state_t        st;
    logic             rx_m, rx_s, rx_prev;
    logic [DIV_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [DIV_W-1:0] eff_div;

    // Purpose: a divider of zero acts as one clock per bit.
    always_comb eff_div = (div == '0) ? DIV_W'(1) : div;

    // Purpose: bring the line into the clock domain and keep one old sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_m    <= 1'b1;
            rx_s    <= 1'b1;
            rx_prev <= 1'b1;
        end else begin
            rx_m    <= rx;
            rx_s    <= rx_m;
            rx_prev <= rx_s;
        end
    end

    // Purpose: frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            data  <= '0;
            valid <= 1'b0;
        end else begin
            valid <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (rx_prev && !rx_s) begin
                        st  <= RX_START;
                        cnt <= eff_div >> 1;
                    end
                end
                RX_START: begin
                    if (cnt == '0) begin
                        if (!rx_s) begin
                            st  <= RX_DATA;
                            cnt <= eff_div - 1'b1;
                            idx <= '0;
                        end else begin
                            st <= RX_IDLE;
                        end
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                RX_DATA: begin
                    if (cnt == '0) begin
                        data <= {rx_s, data[DATA_BITS-1:1]};
                        cnt  <= eff_div - 1'b1;
                        if (idx == IDX_W'(DATA_BITS - 1)) st <= RX_STOP;
                        else idx <= idx + 1'b1;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: begin
                    if (cnt == '0) begin
                        valid <= rx_s;
                        st    <= RX_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/uart_regif.sv
// Bus-facing register block: divider word and combined data port.
// Assumes the master holds a request steady until bus_ready; an all-zero
// bus_wstrb marks a load. Ready is combinational from the request.
module uart_regif
    import uart_regif_pkg::*;
#(
    parameter logic [BUS_W-1:0] DIV_ADDR  = 32'h0200_0004,
    parameter logic [BUS_W-1:0] DATA_ADDR = 32'h0200_0008,
    parameter int               DIV_RESET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic [BUS_W-1:0] bus_addr,
    input  logic [LANES-1:0] bus_wstrb,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             bus_ready,
    output logic             uart_tx,
    input  logic             uart_rx
);
    logic [BUS_W-1:0]     div_q;
    logic                 hit_div, hit_data, is_wr;
    logic                 tx_busy, tx_start, rd_take;
    logic                 rx_valid, rx_full;
    logic [DATA_BITS-1:0] rx_byte, rx_hold;

    // Purpose: address decode and access kind.
    always_comb begin
        hit_div  = bus_valid && (bus_addr == DIV_ADDR);
        hit_data = bus_valid && (bus_addr == DATA_ADDR);
        is_wr    = |bus_wstrb;
        tx_start = hit_data && is_wr && !tx_busy;
        rd_take  = hit_data && !is_wr;
    end

    // Purpose: handshake, with data-port stores held off while sending.
    always_comb bus_ready = hit_div || (hit_data && !(is_wr && tx_busy));

    // Purpose: load data mux; empty receive buffer reads as all ones.
    always_comb begin
        if (hit_div)      bus_rdata = div_q;
        else if (!rx_full) bus_rdata = '1;
        else              bus_rdata = {{(BUS_W-DATA_BITS){1'b0}}, rx_hold};
    end

    // Purpose: divider register, one flop group per byte lane.
    for (genvar g = 0; g < LANES; g++) begin : g_div_lane
        always_ff @(posedge clk) begin
            if (!rst_n)
                div_q[8*g +: 8] <= 8'(DIV_RESET >> (8*g));
            else if (hit_div && bus_wstrb[g])
                div_q[8*g +: 8] <= bus_wdata[8*g +: 8];
        end
    end

    // Purpose: single-entry receive buffer; a new byte wins over a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            rx_hold <= '0;
        end else if (rx_valid) begin
            rx_full <= 1'b1;
            rx_hold <= rx_byte;
        end else if (rd_take) begin
            rx_full <= 1'b0;
        end
    end

    uart_tx_engine #(.DIV_W(BUS_W)) u_tx (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_q),
        .start (tx_start),
        .data  (bus_wdata[DATA_BITS-1:0]),
        .tx    (uart_tx),
        .busy  (tx_busy)
    );

    uart_rx_engine #(.DIV_W(BUS_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (div_q),
        .rx    (uart_rx),
        .valid (rx_valid),
        .data  (rx_byte)
    );
endmodule

// File: rtl/uart_regif_chk.sv
// Property checker for uart_regif, attached by bind.
// Assumes the bus master holds a request steady until bus_ready.
module uart_regif_chk #(
    parameter logic [31:0] DIV_ADDR  = 32'h0200_0004,
    parameter logic [31:0] DATA_ADDR = 32'h0200_0008
) (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_valid,
    input logic [31:0] bus_addr,
    input logic [3:0]  bus_wstrb,
    input logic [31:0] bus_rdata,
    input logic        bus_ready,
    input logic        uart_tx,
    input logic        tx_busy,
    input logic        rx_full,
    input logic        rx_valid
);
    logic data_rd, data_wr, foreign;

    // Purpose: classify the current bus request.
    always_comb begin
        data_rd = bus_valid && bus_addr == DATA_ADDR && bus_wstrb == 4'b0;
        data_wr = bus_valid && bus_addr == DATA_ADDR && bus_wstrb != 4'b0;
        foreign = bus_valid && bus_addr != DATA_ADDR && bus_addr != DIV_ADDR;
    end

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> uart_tx); // R3
    AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> !uart_tx); // R3
    AST_STORE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && tx_busy) |-> !bus_ready); // R4
    AST_PENDING_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && rx_full) |-> bus_rdata[31:8] == 24'h0); // R5
    AST_EMPTY_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_full) |-> bus_rdata == 32'hFFFF_FFFF); // R6
    AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_valid) |=> !rx_full); // R7
    AST_FOREIGN_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        foreign |-> !bus_ready); // R10
endmodule

bind uart_regif uart_regif_chk #(
    .DIV_ADDR  (DIV_ADDR),
    .DATA_ADDR (DATA_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_wstrb (bus_wstrb),
    .bus_rdata (bus_rdata),
    .bus_ready (bus_ready),
    .uart_tx   (uart_tx),
    .tx_busy   (tx_busy),
    .rx_full   (rx_full),
    .rx_valid  (rx_valid)
);

// File: tb/uart_regif_test.sv
module uart_regif_test;
    localparam logic [31:0] A_DIV  = 32'h0200_0004;
    localparam logic [31:0] A_DATA = 32'h0200_0008;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_valid = 0;
    logic [31:0] bus_addr = 0;
    logic [3:0]  bus_wstrb = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic        uart_tx;
    logic        uart_rx = 1;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;
    longint last_acc = 0;
    bit done = 0;

    uart_regif uut (.*);

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] s);
        logic [31:0] r = o;
        for (int i = 0; i < 4; i++) if (s[i]) r[8*i +: 8] = n[8*i +: 8];
        return r;
    endfunction

    function automatic logic [9:0] frame_of(input logic [7:0] b);
        return {1'b1, b, 1'b0};
    endfunction

    task automatic bus_acc(input logic [31:0] a, input logic [31:0] d,
                           input logic [3:0] s, output logic [31:0] rd);
        @(negedge clk);
        bus_valid = 1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
        #1;
        while (!bus_ready) @(negedge clk);
        rd = bus_rdata;
        last_acc = cyc + 1;
        @(posedge clk);
        #1 bus_valid = 0; bus_wstrb = 0;
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        logic [31:0] x;
        bus_acc(a, d, s, x);
    endtask

    task automatic rd_chk(input logic [31:0] a, input logic [31:0] exp,
                          input string req, input string what);
        logic [31:0] x;
        bus_acc(a, 32'h0, 4'h0, x);
        chk(x == exp, req, what, x, exp);
    endtask

    // Samples the frame started by the last accepted store near each bit centre.
    task automatic tx_chk(input logic [7:0] b, input int dv, input string req);
        logic [9:0] got;
        longint base = last_acc;
        for (int i = 0; i < 10; i++) begin
            longint tgt = i * dv + dv / 2 - 1;
            do @(negedge clk); while (cyc - base < tgt);
            got[i] = uart_tx;
        end
        chk(got == frame_of(b), req, "tx frame", {22'h0, got}, {22'h0, frame_of(b)});
        while (cyc - base < 10 * dv + 1) @(negedge clk);
    endtask

    task automatic rx_send(input logic [7:0] b, input bit stop_ok, input int dv);
        logic [9:0] f = {stop_ok, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); uart_rx = f[i];
            repeat (dv - 1) @(negedge clk);
        end
        @(negedge clk); uart_rx = 1;
        repeat (dv + 4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] dv_val;
        longint acc_a;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        chk(uart_tx == 1'b1, "R3", "idle line after reset", {31'h0, uart_tx}, 32'h1);
        rd_chk(A_DIV, 32'h1, "R1", "divider reset value");
        rd_chk(A_DATA, 32'hFFFF_FFFF, "R6", "empty buffer after reset");

        // R1 full word and R2 lane masks
        wr(A_DIV, 32'hAABB_CCDD, 4'hF);
        rd_chk(A_DIV, 32'hAABB_CCDD, "R1", "divider full write");
        wr(A_DIV, 32'h1122_3344, 4'b0101);
        rd_chk(A_DIV, merge(32'hAABB_CCDD, 32'h1122_3344, 4'b0101), "R2", "lane mask 0101");
        wr(A_DIV, 32'h5566_7788, 4'b1000);
        rd_chk(A_DIV, merge(merge(32'hAABB_CCDD, 32'h1122_3344, 4'b0101),
                            32'h5566_7788, 4'b1000), "R2", "lane mask 1000");

        // R10 foreign address: no ready, no register change
        @(negedge clk);
        bus_valid = 1; bus_addr = 32'h0200_0000; bus_wdata = 32'h5; bus_wstrb = 4'hF;
        for (int i = 0; i < 3; i++) begin
            #1 chk(bus_ready == 1'b0, "R10", "foreign ready", {31'h0, bus_ready}, 32'h0);
            @(negedge clk);
        end
        bus_valid = 0; bus_wstrb = 0;
        wr(A_DIV, 32'h4, 4'hF);
        rd_chk(A_DIV, 32'h4, "R10", "divider after foreign store");
        rd_chk(A_DATA, 32'hFFFF_FFFF, "R10", "data after foreign store");

        // R3 directed frames, upper store bits ignored
        wr(A_DATA, 32'hFFFF_FF55, 4'h1);
        tx_chk(8'h55, 4, "R3");
        wr(A_DATA, 32'h0000_0000, 4'hF);
        tx_chk(8'h00, 4, "R3");
        wr(A_DATA, 32'h0000_00FF, 4'h2);
        tx_chk(8'hFF, 4, "R3");

        // R4 back-to-back stores stall until the first frame is done
        wr(A_DATA, 32'h3C, 4'h1);
        acc_a = last_acc;
        wr(A_DATA, 32'hC3, 4'h1);
        chk(last_acc - acc_a == 10 * 4 + 1, "R4", "stall length",
            32'(last_acc - acc_a), 32'(10 * 4 + 1));
        tx_chk(8'hC3, 4, "R4");

        // R5 / R7 receive, load, and empty afterwards
        rx_send(8'hA5, 1, 4);
        rd_chk(A_DATA, 32'h0000_00A5, "R5", "received byte");
        rd_chk(A_DATA, 32'hFFFF_FFFF, "R7", "load consumed byte");

        // R8 bad stop bit dropped, on empty and on pending buffer
        rx_send(8'h5A, 0, 4);
        rd_chk(A_DATA, 32'hFFFF_FFFF, "R8", "bad stop on empty");
        rx_send(8'h81, 1, 4);
        rx_send(8'h7E, 0, 4);
        rd_chk(A_DATA, 32'h0000_0081, "R8", "bad stop keeps old byte");

        // R9 overwrite of unread byte
        rx_send(8'h11, 1, 4);
        rx_send(8'h22, 1, 4);
        rd_chk(A_DATA, 32'h0000_0022, "R9", "newer byte replaces older");
        rd_chk(A_DATA, 32'hFFFF_FFFF, "R7", "empty after overwrite load");

        // Random divider, transmit and receive values
        for (int k = 0; k < 16; k++) begin
            logic [7:0] tb_byte, rb_byte;
            dv_val  = 32'(4 + ($urandom % 9));
            tb_byte = 8'($urandom);
            rb_byte = 8'($urandom);
            wr(A_DIV, dv_val, 4'hF);
            rd_chk(A_DIV, dv_val, "R1", "random divider");
            wr(A_DATA, {24'($urandom), tb_byte}, 4'h1);
            tx_chk(tb_byte, int'(dv_val), "R3");
            rx_send(rb_byte, 1, int'(dv_val));
            rd_chk(A_DATA, {24'h0, rb_byte}, "R5", "random receive");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule